// File: doc/BRIEF.md
# Bus-Programmed Clock Output Controller

This block is the control half of a four-output differential clock buffer. A host on a two-wire SMBus writes and reads a small bank of configuration bytes. Those bytes, together with an output-enable pin and a bypass pin, decide what each of the four clock outputs does. Each output can be off (high impedance), driven from the PLL, or driven from the reference clock. The PLL and the analog drivers are outside the block. The block hands them a 2-bit state code for each output and a flag for vendor test mode.

The bus is sampled with the system clock. SCL and SDA arrive as plain inputs, and the block pulls SDA low through `sda_oe_o`, which is active high. Two strap pins set the low two bits of the 7-bit slave address, so four devices can share one bus. The block supports byte and word transfers in both directions. A command byte selects the register index. A read uses a repeated start after the command byte. There is no bus timeout and there is no packet error code.

The control byte (index 0) has this layout:
- Bit 7: vendor test.
- Bits 6:4: PLL multiplier. The block passes these on and does not decode them.
- Bits 3:0: enables for outputs 3 to 0.

Index 1 is a spare read/write byte. Index 2 is a read-only identity byte.

Top module: `clkout_smb_ctrl`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal {ADDR_HI[4:0], dev_id_i[1:0]}. Address bit 0 selects write (0) or read (1). A transfer to any other address is not acknowledged and changes no register.
- R2: In a write, the byte after the address is the command, which gives the register index. Each data byte is acknowledged and stored at the current index. The index then advances, so a word write fills two consecutive indices.
- R3: After a repeated start with the read bit set, the slave sends the byte at the current index, MSB first. A master acknowledge makes it send the next index. A master not-acknowledge makes it release SDA until the next start.
- R4: Holding SCL low for any length of time never aborts a transfer. The transfer resumes when the clock resumes.
- R5: Index 2 reads as {REV[4:0], VENDOR[2:0]}, 0x1D by default. A write to index 2 is acknowledged and discarded.
- R6: An index above 2 reads 0x00, and a write to it is acknowledged and discarded. The index after 2 is 0.
- R7: When en_i is 0, every output state is 2'b00 (high-Z) and test_mode_o is 0, whatever the registers and the bypass pin hold.
- R8: When en_i is 1 and control bit 7 is 1, test_mode_o is 1 and every output state is 2'b11 (test, no defined source).
- R9: When en_i is 1, control bit 7 is 0 and bypass_n_i is 0, every output state is 2'b10 (reference clock).
- R10: When en_i is 1, control bit 7 is 0 and bypass_n_i is 1, output k's state (bits 2k+1:2k) is 2'b01 (PLL) if control bit k is 1, else 2'b00.
- R11: After reset the control byte is 0x0F, the spare byte is 0x00 and SDA is released, so with en_i=1 and bypass_n_i=1 all outputs run from the PLL (out_state_o = 0x55).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| dev_id_i | input | 2 | Strap pins, low two address bits |
| en_i | input | 1 | Output enable pin, 0 forces all outputs off |
| bypass_n_i | input | 1 | 0 routes the reference clock to all outputs |
| ctrl_byte_o | output | 8 | Register index 0 contents |
| aux_byte_o | output | 8 | Register index 1 contents |
| out_state_o | output | 8 | Per-output state, 2 bits each: 00 off, 01 PLL, 10 reference, 11 test |
| test_mode_o | output | 1 | Vendor test mode active |

## Verification
The decode path is combinational from the register bank. A corrupted control byte therefore shows up on out_state_o as soon as the bus write completes, and it shows again when the byte is read back. A byte engine that loses its bit count or its index shows on the very next acknowledge slot, as a missing or extra low on SDA, or as a read byte shifted by one bit or taken from the neighbouring index. The bench therefore sweeps every address and every combination of enable bits, test bit and pin level. It also hits the index wrap and the discarded writes, and it compares every port against values it computes itself.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
  localparam int NUM_OUT   = 4;
  localparam int NUM_RW    = 2;
  localparam int IDX_CTRL  = 0;
  localparam int IDX_IDENT = 2;
  localparam int TEST_BIT  = 7;
  localparam logic [7:0] CTRL_RESET = 8'h0F;

  typedef enum logic [1:0] {
    OUT_OFF  = 2'b00,
    OUT_PLL  = 2'b01,
    OUT_REF  = 2'b10,
    OUT_TEST = 2'b11
  } out_mode_e;

  function automatic logic [7:0] next_idx(input logic [7:0] i);
    return (i == 8'(IDX_IDENT)) ? 8'd0 : i + 8'd1;
  endfunction

  function automatic logic [7:0] reset_val(input int i);
    return (i == IDX_CTRL) ? CTRL_RESET : 8'h00;
  endfunction
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_o,
  output logic stop_o
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] scl_sh, sda_sh;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[TOP-1:0], scl_i};
      sda_sh <= {sda_sh[TOP-1:0], sda_i};
      scl_q  <= scl_sh[TOP];
      sda_q  <= sda_sh[TOP];
    end
  end

  assign scl_s    = scl_sh[TOP];
  assign sda_s    = sda_sh[TOP];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_o  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o   = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smb_byte_engine.sv
module smb_byte_engine #(
  parameter logic [4:0] ADDR_HI = 5'b11011
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] dev_id_i,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [7:0] rd_data,
  output logic [7:0] rd_idx,
  output logic       wr_en,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_data,
  output logic       sda_oe
);
  import clkout_pkg::*;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_CMD, S_CACK, S_WDAT, S_WACK, S_RDAT, S_RACK
  } eng_state_e;

  eng_state_e st;
  logic [3:0] bitcnt;
  logic [7:0] shreg, idx;
  logic       rw, mack;
  logic [6:0] my_addr;

  assign my_addr = {ADDR_HI, dev_id_i};
  assign rd_idx  = (st == S_RACK) ? next_idx(idx) : idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      idx     <= '0;
      rw      <= 1'b0;
      mack    <= 1'b0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_i) begin
        st     <= S_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_i) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_CMD, S_WDAT: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              if (st == S_ADDR) begin
                if (shreg[7:1] == my_addr) begin
                  rw     <= shreg[0];
                  sda_oe <= 1'b1;
                  st     <= S_AACK;
                end else begin
                  st <= S_IDLE;
                end
              end else if (st == S_CMD) begin
                idx    <= shreg;
                sda_oe <= 1'b1;
                st     <= S_CACK;
              end else begin
                wr_en   <= 1'b1;
                wr_idx  <= idx;
                wr_data <= shreg;
                sda_oe  <= 1'b1;
                st      <= S_WACK;
              end
            end
          end
          S_AACK: if (scl_fall) begin
            bitcnt <= '0;
            if (rw) begin
              shreg  <= rd_data;
              sda_oe <= ~rd_data[7];
              st     <= S_RDAT;
            end else begin
              sda_oe <= 1'b0;
              st     <= S_CMD;
            end
          end
          S_CACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            st     <= S_WDAT;
          end
          S_WACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            idx    <= next_idx(idx);
            st     <= S_WDAT;
          end
          S_RDAT: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
                bitcnt <= '0;
                st     <= S_RACK;
              end else begin
                shreg  <= {shreg[6:0], 1'b0};
                sda_oe <= ~shreg[6];
              end
            end
          end
          S_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                idx    <= next_idx(idx);
                shreg  <= rd_data;
                sda_oe <= ~rd_data[7];
                st     <= S_RDAT;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_ack_own_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_AACK && $past(st) == S_ADDR) |-> ($past(shreg[7:1]) == my_addr));

  assert_idle_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);
endmodule

// File: rtl/clkout_reg_bank.sv
module clkout_reg_bank #(
  parameter logic [4:0] REV    = 5'h03,
  parameter logic [2:0] VENDOR = 3'h5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_idx,
  input  logic [7:0] wr_data,
  input  logic [7:0] rd_idx,
  output logic [7:0] rd_data,
  output logic [7:0] ctrl_byte,
  output logic [7:0] aux_byte
);
  import clkout_pkg::*;
  localparam int IW = (NUM_RW > 1) ? $clog2(NUM_RW) : 1;
  localparam logic [7:0] IDENT = {REV, VENDOR};

  logic [7:0] bank [NUM_RW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_RW; b++) bank[b] <= reset_val(b);
    end else if (wr_en) begin
      for (int b = 0; b < NUM_RW; b++)
        if (wr_idx == 8'(b)) bank[b] <= wr_data;
    end
  end

  always_comb begin
    if (rd_idx < 8'(NUM_RW))            rd_data = bank[rd_idx[IW-1:0]];
    else if (rd_idx == 8'(IDX_IDENT))   rd_data = IDENT;
    else                                rd_data = 8'h00;
  end

  assign ctrl_byte = bank[0];
  assign aux_byte  = bank[1];

  assert_ro_write_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx >= 8'(NUM_RW)) |=> ($stable(ctrl_byte) && $stable(aux_byte)));
endmodule

// File: rtl/clkout_decode.sv
module clkout_decode (
  input  logic       en_i,
  input  logic       bypass_n_i,
  input  logic [7:0] ctrl_byte,
  output logic [2*clkout_pkg::NUM_OUT-1:0] out_state,
  output logic       test_o
);
  import clkout_pkg::*;

  assign test_o = en_i & ctrl_byte[TEST_BIT];

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    out_mode_e m;
    always_comb begin
      if (!en_i)                    m = OUT_OFF;
      else if (ctrl_byte[TEST_BIT]) m = OUT_TEST;
      else if (!bypass_n_i)         m = OUT_REF;
      else if (ctrl_byte[k])        m = OUT_PLL;
      else                          m = OUT_OFF;
    end
    assign out_state[2*k +: 2] = m;
  end
endmodule

// File: rtl/clkout_smb_ctrl.sv
module clkout_smb_ctrl #(
  parameter logic [4:0] ADDR_HI     = 5'b11011,
  parameter logic [4:0] REV         = 5'h03,
  parameter logic [2:0] VENDOR      = 3'h5,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [1:0] dev_id_i,
  input  logic       en_i,
  input  logic       bypass_n_i,
  output logic [7:0] ctrl_byte_o,
  output logic [7:0] aux_byte_o,
  output logic [7:0] out_state_o,
  output logic       test_mode_o
);
  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic wr_en;
  logic [7:0] wr_idx, wr_data, rd_idx, rd_data;

  smb_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_o(start_ev), .stop_o(stop_ev)
  );

  smb_byte_engine #(.ADDR_HI(ADDR_HI)) u_eng (
    .clk(clk), .rst_n(rst_n), .dev_id_i(dev_id_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_i(start_ev), .stop_i(stop_ev),
    .rd_data(rd_data), .rd_idx(rd_idx), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .sda_oe(sda_oe_o)
  );

  clkout_reg_bank #(.REV(REV), .VENDOR(VENDOR)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .ctrl_byte(ctrl_byte_o), .aux_byte(aux_byte_o)
  );

  clkout_decode u_dec (
    .en_i(en_i), .bypass_n_i(bypass_n_i), .ctrl_byte(ctrl_byte_o),
    .out_state(out_state_o), .test_o(test_mode_o)
  );

  assert_off_when_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> (out_state_o == 8'h00 && !test_mode_o));

  assert_test_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode_o |-> (en_i && out_state_o == 8'hFF));
endmodule

// File: tb/clkout_smb_ctrl_tb.sv
module clkout_smb_ctrl_tb;
  localparam int Q = 6;
  localparam int H = 12;
  localparam logic [6:0] DEV = 7'h6E;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [1:0] dev_id = 2'b10;
  logic en = 1'b1, bypass_n = 1'b1;
  logic sda_oe, test_mode;
  logic [7:0] ctrl_b, aux_b, ostate;
  wire  sda_line = m_sda & ~sda_oe;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  clkout_smb_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .dev_id_i(dev_id), .en_i(en), .bypass_n_i(bypass_n), .ctrl_byte_o(ctrl_b),
    .aux_byte_o(aux_b), .out_state_o(ostate), .test_mode_o(test_mode)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(H);
    m_sda = 1'b0; tick(H); m_scl = 1'b0; tick(2);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(H); m_sda = 1'b1; tick(H);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(Q); m_scl = 1'b1; tick(H); m_scl = 1'b0; tick(2);
    end
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(H/2);
    ack = ~sda_line;
    tick(H/2); m_scl = 1'b0; tick(2);
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] d);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); m_scl = 1'b1; tick(H/2); d[i] = sda_line; tick(H/2); m_scl = 1'b0; tick(2);
    end
    m_sda = ~give_ack; tick(Q); m_scl = 1'b1; tick(H); m_scl = 1'b0; tick(2);
    m_sda = 1'b1;
  endtask

  task automatic smb_wr(input logic [6:0] a, input logic [7:0] cmd,
                        input logic [7:0] d0, input logic [7:0] d1,
                        input int n, output logic ok);
    logic k0, k1, k2, k3;
    bus_start();
    wbyte({a, 1'b0}, k0);
    wbyte(cmd, k1);
    wbyte(d0, k2);
    k3 = 1'b1;
    if (n > 1) wbyte(d1, k3);
    bus_stop();
    ok = k0 & k1 & k2 & k3;
  endtask

  task automatic smb_rd(input logic [6:0] a, input logic [7:0] cmd, input int n,
                        output logic [7:0] r0, output logic [7:0] r1, output logic ok);
    logic k0, k1, k2;
    bus_start();
    wbyte({a, 1'b0}, k0);
    wbyte(cmd, k1);
    bus_start();
    wbyte({a, 1'b1}, k2);
    rbyte(n > 1, r0);
    r1 = 8'h00;
    if (n > 1) rbyte(1'b0, r1);
    bus_stop();
    ok = k0 & k1 & k2;
  endtask

  function automatic logic [7:0] exp_state(input logic e, input logic bpn, input logic [7:0] c);
    logic [7:0] r;
    for (int k = 0; k < 4; k++) begin
      if (!e)        r[2*k +: 2] = 2'b00;
      else if (c[7]) r[2*k +: 2] = 2'b11;
      else if (!bpn) r[2*k +: 2] = 2'b10;
      else           r[2*k +: 2] = {1'b0, c[k]};
    end
    return r;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic ok, k;
    logic [7:0] r0, r1;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R11 reset state
    chk("R11 ctrl", ctrl_b, 8'h0F);
    chk("R11 aux", aux_b, 8'h00);
    chk("R11 sda", sda_oe, 0);
    chk("R11 state", ostate, 8'h55);
    chk("R11 test", test_mode, 0);

    // R1 address sweep
    for (int a = 0; a < 128; a++) begin
      bus_start();
      wbyte({7'(a), 1'b0}, k);
      bus_stop();
      chk("R1 addr ack", k, (7'(a) == DEV));
    end
    dev_id = 2'b01;
    smb_wr(7'h6D, 8'd1, 8'hA5, 8'h00, 1, ok);
    chk("R1 strap addr ok", ok, 1);
    chk("R1 strap write", aux_b, 8'hA5);
    smb_wr(7'h6E, 8'd1, 8'h3C, 8'h00, 1, ok);
    chk("R1 old addr nack", ok, 0);
    chk("R1 no write", aux_b, 8'hA5);
    dev_id = 2'b10;

    // R2 R3 byte write and read
    smb_wr(DEV, 8'd1, 8'h5A, 8'h00, 1, ok);
    chk("R2 byte ack", ok, 1);
    smb_rd(DEV, 8'd1, 1, r0, r1, ok);
    chk("R3 byte read", r0, 8'h5A);
    chk("R3 released", sda_oe, 0);

    // R2 R3 word
    smb_wr(DEV, 8'd0, 8'h3C, 8'h77, 2, ok);
    chk("R2 word ack", ok, 1);
    chk("R2 word b0", ctrl_b, 8'h3C);
    chk("R2 word b1", aux_b, 8'h77);
    smb_rd(DEV, 8'd0, 2, r0, r1, ok);
    chk("R3 word r0", r0, 8'h3C);
    chk("R3 word r1", r1, 8'h77);

    // R5 identity byte
    smb_rd(DEV, 8'd2, 1, r0, r1, ok);
    chk("R5 ident", r0, 8'h1D);
    smb_wr(DEV, 8'd2, 8'hFF, 8'h00, 1, ok);
    chk("R5 write acked", ok, 1);
    smb_rd(DEV, 8'd2, 1, r0, r1, ok);
    chk("R5 ident kept", r0, 8'h1D);
    chk("R5 ctrl kept", ctrl_b, 8'h3C);
    chk("R5 aux kept", aux_b, 8'h77);

    // R6 undefined index and wrap
    smb_wr(DEV, 8'd5, 8'hAA, 8'h00, 1, ok);
    chk("R6 write acked", ok, 1);
    chk("R6 ctrl kept", ctrl_b, 8'h3C);
    chk("R6 aux kept", aux_b, 8'h77);
    smb_rd(DEV, 8'd5, 1, r0, r1, ok);
    chk("R6 read zero", r0, 8'h00);
    smb_rd(DEV, 8'd2, 2, r0, r1, ok);
    chk("R6 wrap r0", r0, 8'h1D);
    chk("R6 wrap r1", r1, 8'h3C);
    smb_wr(DEV, 8'd2, 8'hFF, 8'h2B, 2, ok);
    chk("R6 wrap write", ctrl_b, 8'h2B);
    chk("R6 wrap aux kept", aux_b, 8'h77);

    // R4 clock stretched low far beyond any timeout
    bus_start();
    wbyte({DEV, 1'b0}, k);
    wbyte(8'd1, k);
    tick(3000);
    wbyte(8'h99, k);
    chk("R4 ack after stall", k, 1);
    bus_stop();
    chk("R4 data", aux_b, 8'h99);

    // R7 R8 R9 R10 decode sweep
    for (int v = 0; v < 32; v++) begin
      logic [7:0] c;
      c = {v[4], v[2:0], v[3:0]};
      smb_wr(DEV, 8'd0, c, 8'h00, 1, ok);
      chk("R2 ctrl write", ctrl_b, c);
      for (int p = 0; p < 4; p++) begin
        en = p[1]; bypass_n = p[0];
        tick(2);
        if (!en) begin
          chk("R7 state", ostate, 8'h00);
          chk("R7 test", test_mode, 0);
        end else if (c[7]) begin
          chk("R8 state", ostate, exp_state(en, bypass_n, c));
          chk("R8 test", test_mode, 1);
        end else if (!bypass_n) begin
          chk("R9 state", ostate, exp_state(en, bypass_n, c));
        end else begin
          chk("R10 state", ostate, exp_state(en, bypass_n, c));
          chk("R10 test", test_mode, 0);
        end
      end
      en = 1'b1; bypass_n = 1'b1;
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule